// File: doc/BRIEF.md
# Channel Clock Output Mode Controller

This block is the synchronous control logic of a differential memory-channel clock generator. It decides which clock reaches the true and complement output pins: the phase-aligned clock, the raw PLL clock or the reference clock. It also drives an enable and a force-low control for each pin, and it decodes the multiplier-select code into the PLL feedback divider A and prescaler divider B. The analog PLL and the pad drivers are outside the block, and each pin is modelled as a value plus an enable.

The mode selection is latched only while power-down is asserted, so it has no effect while the device is running. The multiplier code may change at any time. When it moves to a new legal code while the device is running, a settling flag stays high for a parameterised number of reference cycles. The stop input releases the pins to high impedance while the device keeps running. The power-down input forces both pins low.

Top module: `clkModeCtl`

## Requirements
- R1: When the latched mode is 0 and both control inputs are high, srcSel is 0 (aligned clock) and trueOe and compOe are both 1.
- R2: Latched mode 1 (bypass) gives srcSel 1 (PLL clock) with both outputs enabled.
- R3: Latched mode 3 (reference test) gives srcSel 2 (reference clock) with both outputs enabled.
- R4: Latched modes 2 and 6 (output test) give srcSel 3, both outputs disabled and neither forced low.
- R5: Latched modes 4, 5 and 7 (vendor and reserved) give srcSel 3 with both outputs disabled.
- R6: With pwrDnN high and stopN low, both enables are 0 and both force-lows are 0 (high impedance), and srcSel still reflects the latched mode.
- R7: With pwrDnN low, srcSel is 3, both enables are 0 and both force-lows are 1. poweredDown is a registered copy of the inverted pwrDnN, valid one clock later.
- R8: modeSel is captured on every clock while pwrDnN is low and is ignored while pwrDnN is high.
- R9: multSel is decoded one clock after it is presented: 0→(A=4,B=1), 1→(9,2), 2→(6,1), 4→(8,3), 5→(16,3), 6→(8,1).
- R10: multSel values 3 and 7 set multInvalid on the next clock and leave divA and divB unchanged. A legal code clears multInvalid.
- R11: A change of multSel to a legal code while pwrDnN is high raises settling for exactly SETTLE_CYCLES clocks. A change during power-down does not raise it, and power-down clears it.
- R12: Reset (rstN low) gives latched mode 0, A=4, B=1, multInvalid 0, settling 0 and poweredDown 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Mode select, bit 0 first |
| multSel | input | 3 | Multiplier select code |
| stopN | input | 1 | Active-low output stop |
| pwrDnN | input | 1 | Active-low power-down |
| srcSel | output | 2 | Output source: 0 aligned, 1 PLL, 2 reference, 3 none |
| trueOe | output | 1 | True pin driver enable |
| compOe | output | 1 | Complement pin driver enable |
| trueForceLow | output | 1 | Drive true pin to ground |
| compForceLow | output | 1 | Drive complement pin to ground |
| divA | output | 5 | Feedback divider A |
| divB | output | 2 | Prescaler divider B |
| multInvalid | output | 1 | Last multiplier code was undefined |
| settling | output | 1 | PLL settling after a live multiplier change |
| poweredDown | output | 1 | Registered power-down state |

## Verification
The hardest situations to reach are a latched mode that differs from the value on modeSel, and a multiplier change that must be told apart as running or powered down. The stimulus first enters power-down to latch one mode. It then releases power-down and moves modeSel to another value while running, so the ignored bits can be seen on srcSel. Multiplier changes are issued both inside and outside power-down. An undefined code is placed between two legal codes, so the held divider values and the settle window are compared every cycle against a behavioural model.

// File: rtl/clkModePkg.sv
package clkModePkg;
  localparam int DIV_A_W = 5;
  localparam int DIV_B_W = 2;

  typedef enum logic [1:0] {
    SRC_ALIGN = 2'd0,
    SRC_PLL   = 2'd1,
    SRC_REF   = 2'd2,
    SRC_OFF   = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic captureMode;
    logic loadDiv;
    logic markInvalid;
    logic startSettle;
    logic clearSettle;
  } ctlStrobe_t;

  typedef struct packed {
    logic               valid;
    logic [DIV_A_W-1:0] a;
    logic [DIV_B_W-1:0] b;
  } divPair_t;

  function automatic divPair_t decodeMult(input logic [2:0] code);
    divPair_t r;
    r = '{valid: 1'b0, a: DIV_A_W'(4), b: DIV_B_W'(1)};
    case (code)
      3'd0: r = '{valid: 1'b1, a: DIV_A_W'(4),  b: DIV_B_W'(1)};
      3'd1: r = '{valid: 1'b1, a: DIV_A_W'(9),  b: DIV_B_W'(2)};
      3'd2: r = '{valid: 1'b1, a: DIV_A_W'(6),  b: DIV_B_W'(1)};
      3'd4: r = '{valid: 1'b1, a: DIV_A_W'(8),  b: DIV_B_W'(3)};
      3'd5: r = '{valid: 1'b1, a: DIV_A_W'(16), b: DIV_B_W'(3)};
      3'd6: r = '{valid: 1'b1, a: DIV_A_W'(8),  b: DIV_B_W'(1)};
      default: r.valid = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkModeCtlCtrl.sv
module clkModeCtlCtrl
  import clkModePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] multSel,
  input  logic       pwrDnN,
  output ctlStrobe_t strobe
);
  logic [2:0] multPrev;
  divPair_t   dec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) multPrev <= 3'd0;
    else       multPrev <= multSel;
  end

  always_comb begin
    dec                = decodeMult(multSel);
    strobe.captureMode = !pwrDnN;
    strobe.clearSettle = !pwrDnN;
    strobe.loadDiv     = dec.valid;
    strobe.markInvalid = !dec.valid;
    strobe.startSettle = pwrDnN && dec.valid && (multSel != multPrev);
  end
endmodule

// File: rtl/clkModeCtlDp.sv
module clkModeCtlDp
  import clkModePkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [2:0]         modeSel,
  input  logic [2:0]         multSel,
  input  logic               stopN,
  input  logic               pwrDnN,
  output logic [1:0]         srcSel,
  output logic               trueOe,
  output logic               compOe,
  output logic               trueForceLow,
  output logic               compForceLow,
  output logic [DIV_A_W-1:0] divA,
  output logic [DIV_B_W-1:0] divB,
  output logic               multInvalid,
  output logic               settling,
  output logic               poweredDown
);
  logic [2:0] modeQ;
  divPair_t   dec;
  srcSel_e    srcNext;
  logic       drvEn;

  always_comb dec = decodeMult(multSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= 3'd0;
      divA        <= DIV_A_W'(4);
      divB        <= DIV_B_W'(1);
      multInvalid <= 1'b0;
      poweredDown <= 1'b0;
    end else begin
      poweredDown <= !pwrDnN;
      if (strobe.captureMode) modeQ <= modeSel;
      if (strobe.loadDiv) begin
        divA        <= dec.a;
        divB        <= dec.b;
        multInvalid <= 1'b0;
      end else if (strobe.markInvalid) begin
        multInvalid <= 1'b1;
      end
    end
  end

  generate
    if (SETTLE_CYCLES > 0) begin : g_settle
      localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
      logic [CNT_W-1:0] settleCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  settleCnt <= '0;
        else if (strobe.clearSettle) settleCnt <= '0;
        else if (strobe.startSettle) settleCnt <= CNT_W'(SETTLE_CYCLES);
        else if (settleCnt != '0)   settleCnt <= settleCnt - 1'b1;
      end
      assign settling = (settleCnt != '0);
    end else begin : g_noSettle
      assign settling = 1'b0;
    end
  endgenerate

  always_comb begin
    srcNext   = SRC_OFF;
    drvEn     = 1'b0;
    trueForceLow = 1'b0;
    compForceLow = 1'b0;
    if (!pwrDnN) begin
      trueForceLow = 1'b1;
      compForceLow = 1'b1;
    end else begin
      case (modeQ)
        3'b000:  srcNext = SRC_ALIGN;
        3'b001:  srcNext = SRC_PLL;
        3'b011:  srcNext = SRC_REF;
        default: srcNext = SRC_OFF;
      endcase
      drvEn = (srcNext != SRC_OFF) && stopN;
    end
    srcSel = srcNext;
    trueOe = drvEn;
    compOe = drvEn;
  end
endmodule

// File: rtl/clkModeCtl.sv
module clkModeCtl
  import clkModePkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic [2:0] multSel,
  input  logic       stopN,
  input  logic       pwrDnN,
  output logic [1:0] srcSel,
  output logic       trueOe,
  output logic       compOe,
  output logic       trueForceLow,
  output logic       compForceLow,
  output logic [4:0] divA,
  output logic [1:0] divB,
  output logic       multInvalid,
  output logic       settling,
  output logic       poweredDown
);
  ctlStrobe_t strobe;

  clkModeCtlCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .multSel(multSel), .pwrDnN(pwrDnN), .strobe(strobe)
  );

  clkModeCtlDp #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeSel(modeSel),
    .multSel(multSel), .stopN(stopN), .pwrDnN(pwrDnN), .srcSel(srcSel),
    .trueOe(trueOe), .compOe(compOe), .trueForceLow(trueForceLow),
    .compForceLow(compForceLow), .divA(divA), .divB(divB),
    .multInvalid(multInvalid), .settling(settling), .poweredDown(poweredDown)
  );
endmodule

// File: rtl/clkModeCtlChk.sv
module clkModeCtlChk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] multSel,
  input logic       stopN,
  input logic       pwrDnN,
  input logic       trueOe,
  input logic       compOe,
  input logic       trueForceLow,
  input logic [4:0] divA,
  input logic [1:0] divB,
  input logic       multInvalid,
  input logic       settling,
  input logic       poweredDown
);
  // R7
  pd_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDnN |=> poweredDown);

  // R7
  pd_ground_chk: assert property (@(posedge clk) disable iff (!rstN)
    poweredDown && !pwrDnN |-> trueForceLow && !trueOe);

  // R6
  stop_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stopN |-> !trueOe && !compOe);

  // R10
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (multSel == 3'd3 || multSel == 3'd7) |=> multInvalid && $stable(divA) && $stable(divB));

  // R11
  settle_pd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDnN |=> !settling);
endmodule

bind clkModeCtl clkModeCtlChk u_chk (
  .clk(clk), .rstN(rstN), .multSel(multSel), .stopN(stopN), .pwrDnN(pwrDnN),
  .trueOe(trueOe), .compOe(compOe), .trueForceLow(trueForceLow),
  .divA(divA), .divB(divB), .multInvalid(multInvalid),
  .settling(settling), .poweredDown(poweredDown)
);

// File: tb/clkModeCtl_test.sv
module clkModeCtl_test;
  localparam int SETTLE = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [2:0] multSel = 3'd0;
  logic       stopN = 1'b1;
  logic       pwrDnN = 1'b1;
  logic [1:0] srcSel;
  logic       trueOe, compOe, trueForceLow, compForceLow;
  logic [4:0] divA;
  logic [1:0] divB;
  logic       multInvalid, settling, poweredDown;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int mMode = 0, mA = 4, mB = 1, mCnt = 0, mPrev = 0;
  bit mInv = 0, mPd = 0;

  clkModeCtl #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .multSel(multSel),
    .stopN(stopN), .pwrDnN(pwrDnN), .srcSel(srcSel), .trueOe(trueOe),
    .compOe(compOe), .trueForceLow(trueForceLow), .compForceLow(compForceLow),
    .divA(divA), .divB(divB), .multInvalid(multInvalid),
    .settling(settling), .poweredDown(poweredDown)
  );

  always #5 clk = ~clk;

  function automatic bit legal(int c);
    return !(c == 3 || c == 7);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode <= 0; mA <= 4; mB <= 1; mCnt <= 0; mPrev <= 0; mInv <= 0; mPd <= 0;
    end else begin
      int c;
      c = int'(multSel);
      mPd   <= !pwrDnN;
      mPrev <= c;
      if (!pwrDnN) mMode <= int'(modeSel);
      if (legal(c)) begin
        mInv <= 0;
        case (c)
          0: begin mA <= 4;  mB <= 1; end
          1: begin mA <= 9;  mB <= 2; end
          2: begin mA <= 6;  mB <= 1; end
          4: begin mA <= 8;  mB <= 3; end
          5: begin mA <= 16; mB <= 3; end
          default: begin mA <= 8; mB <= 1; end
        endcase
      end else mInv <= 1;
      if (!pwrDnN) mCnt <= 0;
      else if (legal(c) && c != mPrev) mCnt <= SETTLE;
      else if (mCnt > 0) mCnt <= mCnt - 1;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    int eSrc, eOe, eFl;
    if (!pwrDnN) begin eSrc = 3; eOe = 0; eFl = 1; end
    else begin
      case (mMode)
        0: eSrc = 0;
        1: eSrc = 1;
        3: eSrc = 2;
        default: eSrc = 3;
      endcase
      eOe = (eSrc != 3 && stopN) ? 1 : 0;
      eFl = 0;
    end
    chk(tag, "srcSel", int'(srcSel), eSrc);
    chk(tag, "trueOe", int'(trueOe), eOe);
    chk(tag, "compOe", int'(compOe), eOe);
    chk(tag, "trueForceLow", int'(trueForceLow), eFl);
    chk(tag, "compForceLow", int'(compForceLow), eFl);
    chk(tag, "divA", int'(divA), mA);
    chk(tag, "divB", int'(divB), mB);
    chk(tag, "multInvalid", int'(multInvalid), int'(mInv));
    chk(tag, "settling", int'(settling), (mCnt > 0) ? 1 : 0);
    chk(tag, "poweredDown", int'(poweredDown), int'(mPd));
  endtask

  task automatic step(string tag, int md, int mu, bit st, bit pd, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      modeSel = 3'(md); multSel = 3'(mu); stopN = st; pwrDnN = pd;
      #1 compareAll(tag);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modeSel = 3'd5; multSel = 3'd6;
    repeat (3) @(negedge clk);
    #1 compareAll("R12");
    @(negedge clk);
    modeSel = 3'd0; multSel = 3'd0;
    rstN = 1'b1;
    step("R1",  0, 0, 1, 1, 3);
    step("R11", 0, 2, 1, 1, SETTLE + 3);   // live change starts settle window
    step("R9",  0, 1, 1, 1, 2);
    step("R7",  1, 1, 1, 0, 3);            // latch bypass during power-down
    step("R2",  1, 1, 1, 1, 2);
    step("R8",  3, 1, 1, 1, 3);            // modeSel ignored while running
    step("R6",  3, 1, 0, 1, 3);
    step("R2",  0, 1, 1, 1, 2);
    step("R11", 0, 4, 1, 0, 3);            // change in power-down: no settle
    step("R3",  3, 4, 1, 0, 2);
    step("R3",  3, 4, 1, 1, 3);
    step("R6",  3, 4, 0, 1, 2);
    step("R4",  2, 4, 1, 0, 2);
    step("R4",  2, 4, 1, 1, 2);
    step("R4",  6, 4, 1, 0, 2);
    step("R4",  6, 4, 1, 1, 2);
    step("R5",  4, 4, 1, 0, 2);
    step("R5",  4, 4, 1, 1, 2);
    step("R5",  5, 4, 1, 0, 2);
    step("R5",  5, 4, 1, 1, 2);
    step("R5",  7, 4, 1, 0, 2);
    step("R5",  7, 4, 1, 1, 2);
    step("R1",  0, 4, 1, 0, 2);
    step("R1",  0, 4, 1, 1, 2);
    step("R10", 0, 3, 1, 1, 3);
    step("R10", 0, 5, 1, 1, 3);
    step("R10", 0, 7, 1, 1, 3);
    step("R11", 0, 6, 1, 1, 4);
    step("R11", 0, 6, 1, 0, 2);            // power-down clears settle
    for (int c = 0; c < 8; c++) step("R9", 0, c, 1, 1, 2);
    step("R11", 0, 0, 1, 1, SETTLE + 2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule